// File: doc/BRIEF.md
# Sample Word Packing Buffer

This block sits between a conversion sequencer and a 32-bit read port. Each sample arrives with a 3-bit channel number. The block turns samples into 32-bit words and queues the words in a 16-entry first-in first-out store. Software or a DMA engine then drains the store one word at a time.

Two static settings choose the word layout. One setting puts either one or two samples in each word. The other setting chooses whether the channel number goes into the word beside its sample. The block drives four flags:

- empty, which follows the live state of the store;
- full;
- a sticky overflow flag, raised when a word is lost;
- a request flag, raised once the fill count reaches a programmed level.

An interrupt controller can use these flags. A synchronous flush returns the store, the half-built word and the overflow flag to their idle state.

Top module: `smp_pack_fifo`

## Requirements
- R1: After reset, `empty` is 1 and `full`, `overflow` and `level_req` are 0, as long as `cfg_level` is nonzero.
- R2: With `cfg_dual`=0, every accepted sample makes one word. The sample sits in bits 11:0 and bits 31:15 are zero.
- R3: Tag placement follows `cfg_tag_en`. When it is 1, the channel number occupies bits 14:12 of its half word. When it is 0, those bits are zero.
- R4: With `cfg_dual`=1, the first sample of a pair is held back and no word is written for it. The second sample then completes the word: the first sample and its tag sit in bits 14:0, the second sample in bits 27:16 and its tag in bits 30:28. Bits 15 and 31 are zero.
- R5: `rd_data` always shows the oldest stored word while `empty` is 0. A cycle with `rd_en`=1 removes that word, so words leave in the order they were written.
- R6: `empty` is 1 exactly when 0 words are stored. `full` is 1 exactly when 16 words are stored.
- R7: If a completed word arrives while 16 words are stored and no read happens in that cycle, the word is dropped and the stored words are unchanged. `overflow` then rises and stays 1 until a flush or reset.
- R8: If a completed word and a read fall in the same cycle while the store is full, both take effect. The oldest word leaves, the new word enters, `full` stays 1 and `overflow` does not rise.
- R9: `level_req` is 1 exactly when the number of stored words is at least `cfg_level`.
- R10: A cycle with `flush`=1 empties the store and clears `overflow`. It also discards any held half word and any sample or read presented in that same cycle.
- R11: A read while the store is empty has no effect. `empty` stays 1, and the next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 0: one sample per word, 1: two samples per word |
| cfg_tag_en | input | 1 | 1: insert the channel number beside each sample |
| cfg_level | input | 5 | Fill level at which `level_req` rises |
| flush | input | 1 | Synchronous flush of store, held half word and overflow |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | 12 | Sample value |
| in_chan | input | 3 | Channel number of the sample |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest stored word (show-ahead) |
| empty | output | 1 | No words stored |
| full | output | 1 | 16 words stored |
| level_req | output | 1 | Fill count at or above `cfg_level` |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
Two events can collide in a single cycle: a word completing on the write side and a word leaving on the read side. This matters most when the store holds 16 words. The bench fills the store, confirms that one further sample is dropped and raises `overflow`, and then presents a sample together with `rd_en`. The scoreboard expects the oldest word to appear on the read port, the new word to join the tail of the queue and `full` to stay high. A flush that arrives together with a sample and with a pending half word is also provoked. The words read afterwards show that nothing from before the flush survives.

// File: rtl/spf_pkg.sv
package spf_pkg;

    localparam int SMP_W      = 12;
    localparam int CH_W       = 3;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int FIFO_DEPTH = 16;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [SMP_W-1:0] smp;
    } sample_t;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        FMT_SINGLE = 1'b0,
        FMT_DUAL   = 1'b1
    } fmt_e;

    // Build one half word: sample low, optional channel tag above it.
    function automatic half_t make_half(sample_t s, logic tag_en);
        half_t h;
        h = '0;
        h[SMP_W-1:0] = s.smp;
        if (tag_en) begin
            h[SMP_W +: CH_W] = s.chan;
        end
        return h;
    endfunction

endpackage

// File: rtl/spf_packer.sv
module spf_packer
    import spf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  fmt_e    fmt,
    input  logic    tag_en,
    input  logic    in_valid,
    input  sample_t in_smp,
    output logic    out_valid,
    output word_t   out_word
);

    logic  half_valid_q;
    half_t half_q;
    half_t cur_half;

    always_comb begin
        cur_half = make_half(in_smp, tag_en);
        if (fmt == FMT_SINGLE) begin
            out_valid = in_valid && !flush;
            out_word  = {{(WORD_W-HALF_W){1'b0}}, cur_half};
        end else begin
            out_valid = in_valid && half_valid_q && !flush;
            out_word  = {cur_half, half_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            half_valid_q <= 1'b0;
            half_q       <= '0;
        end else if (in_valid && fmt == FMT_DUAL) begin
            if (half_valid_q) begin
                half_valid_q <= 1'b0;
            end else begin
                half_valid_q <= 1'b1;
                half_q       <= cur_half;
            end
        end
    end

    // In paired mode every accepted sample flips the held-half state.
    AST_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_DUAL && in_valid && !flush) |=> (half_valid_q != $past(half_valid_q))) // R4
        else $error("pair state did not toggle");

    // A first sample of a pair never produces a word.
    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_DUAL && in_valid && !flush && !half_valid_q) |=> half_valid_q) // R4
        else $error("first sample not held");

endmodule

// File: rtl/spf_store.sv
module spf_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              wr_drop
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop, push;

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop     = rd_req && (cnt_q != '0) && !flush;
    assign push    = wr_req && !flush && ((cnt_q != CNT_W'(DEPTH)) || pop);
    assign wr_drop = wr_req && !flush && !push;
    assign rd_data = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= nxt(wp_q);
            if (pop)  rp_q <= nxt(rp_q);
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wr_data;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH)) // R6
        else $error("count beyond depth");

    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (wr_drop && !rd_req) |=> (cnt_q == CNT_W'(DEPTH))) // R7
        else $error("drop changed count");

endmodule

// File: rtl/spf_flags.sv
module spf_flags #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             wr_drop,
    output logic             empty,
    output logic             full,
    output logic             level_req,
    output logic             overflow
);

    logic ovf_q;

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign level_req = (count >= level);
    assign overflow  = ovf_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ovf_q <= 1'b0;
        end else if (wr_drop) begin
            ovf_q <= 1'b1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !flush) |=> ovf_q) // R7
        else $error("overflow not sticky");

endmodule

// File: rtl/smp_pack_fifo.sv
module smp_pack_fifo
    import spf_pkg::*;
#(
    parameter int DEPTH = spf_pkg::FIFO_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_dual,
    input  logic                         cfg_tag_en,
    input  logic [$clog2(DEPTH+1)-1:0]   cfg_level,
    input  logic                         flush,
    input  logic                         in_valid,
    input  logic [SMP_W-1:0]             in_sample,
    input  logic [CH_W-1:0]              in_chan,
    input  logic                         rd_en,
    output logic [WORD_W-1:0]            rd_data,
    output logic                         empty,
    output logic                         full,
    output logic                         level_req,
    output logic                         overflow
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    sample_t          smp;
    fmt_e             fmt;
    logic             pk_valid;
    word_t            pk_word;
    logic [CNT_W-1:0] count;
    logic             wr_drop;

    assign smp = '{chan: in_chan, smp: in_sample};
    assign fmt = cfg_dual ? FMT_DUAL : FMT_SINGLE;

    spf_packer u_packer (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .fmt       (fmt),
        .tag_en    (cfg_tag_en),
        .in_valid  (in_valid),
        .in_smp    (smp),
        .out_valid (pk_valid),
        .out_word  (pk_word)
    );

    spf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_req  (pk_valid),
        .wr_data (pk_word),
        .rd_req  (rd_en),
        .rd_data (rd_data),
        .count   (count),
        .wr_drop (wr_drop)
    );

    spf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .count     (count),
        .level     (cfg_level),
        .wr_drop   (wr_drop),
        .empty     (empty),
        .full      (full),
        .level_req (level_req),
        .overflow  (overflow)
    );

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && !overflow)) // R10
        else $error("flush left state behind");

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(empty && full)) // R6
        else $error("empty and full together");

    AST_FULL_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (full && pk_valid && rd_en && !flush) |=> (full && $stable(overflow))) // R8
        else $error("collision at full mishandled");

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !pk_valid) |=> empty) // R11
        else $error("read on empty changed state");

endmodule

// File: tb/test_smp_pack_fifo.sv
`timescale 1ns/1ps
module test_smp_pack_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dual = 1'b0;
    logic        cfg_tag_en = 1'b1;
    logic [4:0]  cfg_level = 5'd8;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic [2:0]  in_chan = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        empty, full, level_req, overflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    bit          m_hv = 0;
    logic [15:0] m_half = '0;
    bit          m_ovf = 0;
    string       cur_req = "R5";

    always #2.5 clk = ~clk;

    smp_pack_fifo i_smp_pack_fifo (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_tag_en(cfg_tag_en),
        .cfg_level(cfg_level), .flush(flush), .in_valid(in_valid),
        .in_sample(in_sample), .in_chan(in_chan), .rd_en(rd_en),
        .rd_data(rd_data), .empty(empty), .full(full),
        .level_req(level_req), .overflow(overflow)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_half(logic [11:0] s, logic [2:0] c);
        return {1'b0, (cfg_tag_en ? c : 3'b000), s};
    endfunction

    // Monitor: compares the word removed by each read with the scoreboard.
    always @(negedge clk) begin
        if (!rst && rd_en && !flush) begin
            if (exp_q.size() == 0) begin
                check("R11 empty on idle read", {31'b0, empty}, 32'd1);
            end else begin
                check(cur_req, rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic check_flags();
        check("R6 empty", {31'b0, empty}, {31'b0, exp_q.size() == 0});
        check("R6 full", {31'b0, full}, {31'b0, exp_q.size() == 16});
        check("R9 level_req", {31'b0, level_req}, {31'b0, exp_q.size() >= int'(cfg_level)});
        check("R7 overflow", {31'b0, overflow}, {31'b0, m_ovf});
    endtask

    // Driver: presents one cycle of stimulus and updates the scoreboard.
    task automatic step(logic v, logic [11:0] s, logic [2:0] c, logic rd, logic fl);
        bit          wv;
        logic [31:0] w;
        in_valid = v; in_sample = s; in_chan = c; rd_en = rd; flush = fl;
        wv = 0; w = '0;
        if (fl) begin
            exp_q.delete();
            m_hv = 0;
            m_ovf = 0;
        end else if (v) begin
            if (!cfg_dual) begin
                wv = 1; w = {16'h0, exp_half(s, c)};
            end else if (m_hv) begin
                wv = 1; w = {exp_half(s, c), m_half}; m_hv = 0;
            end else begin
                m_half = exp_half(s, c); m_hv = 1;
            end
            if (wv) begin
                if (exp_q.size() < 16 || (rd && exp_q.size() > 0)) exp_q.push_back(w);
                else m_ovf = 1;
            end
        end
        @(posedge clk);
        #1;
        in_valid = 0; rd_en = 0; flush = 0;
        check_flags();
    endtask

    task automatic drain();
        while (exp_q.size() > 0) step(0, '0, '0, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        check("R1 empty", {31'b0, empty}, 32'd1);
        check("R1 full", {31'b0, full}, 32'd0);
        check("R1 overflow", {31'b0, overflow}, 32'd0);
        check("R1 level_req", {31'b0, level_req}, 32'd0);

        cur_req = "R2 R3 R5 single tagged";
        step(1, 12'hABC, 3'd5, 0, 0);
        step(1, 12'h123, 3'd2, 0, 0);
        step(1, 12'hFFF, 3'd7, 0, 0);
        drain();

        cfg_tag_en = 0;
        cur_req = "R3 untagged";
        step(1, 12'h5A5, 3'd6, 0, 0);
        step(1, 12'h0F0, 3'd1, 0, 0);
        drain();

        cur_req = "R11 after idle read";
        step(0, '0, '0, 1, 0);
        step(0, '0, '0, 1, 0);
        step(1, 12'h321, 3'd3, 0, 0);
        drain();

        cfg_tag_en = 1;
        cur_req = "R7 R8 R5 full";
        for (int i = 0; i < 18; i++) step(1, 12'(i * 37 + 1), 3'(i), 0, 0);
        check("R7 overflow set", {31'b0, overflow}, 32'd1);
        step(1, 12'h777, 3'd4, 1, 0);
        check("R8 full held", {31'b0, full}, 32'd1);
        step(0, '0, '0, 0, 0);
        check("R7 overflow sticky", {31'b0, overflow}, 32'd1);
        drain();

        cur_req = "R10 flush";
        step(1, 12'h111, 3'd1, 0, 0);
        step(1, 12'h222, 3'd2, 0, 0);
        step(1, 12'h333, 3'd3, 1, 1);
        check("R10 empty after flush", {31'b0, empty}, 32'd1);
        check("R10 overflow cleared", {31'b0, overflow}, 32'd0);
        step(1, 12'h444, 3'd4, 0, 0);
        drain();

        cfg_dual = 1;
        cur_req = "R4 paired";
        step(1, 12'h9AB, 3'd1, 0, 0);
        check("R4 first sample held", {31'b0, empty}, 32'd1);
        step(1, 12'h456, 3'd6, 0, 0);
        check("R4 word written", {31'b0, empty}, 32'd0);
        step(1, 12'hDEF, 3'd7, 0, 0);
        step(1, 12'hBAD, 3'd2, 0, 1);
        step(1, 12'h0A1, 3'd3, 0, 0);
        step(1, 12'h0B2, 3'd4, 0, 0);
        cur_req = "R4 R10 half discarded";
        drain();

        cfg_level = 5'd3;
        cur_req = "R9 level";
        for (int i = 0; i < 8; i++) step(1, 12'(i + 100), 3'(i), 0, 0);
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule